// File: doc/BRIEF.md
# Clock Output Power-Down Gater

This block sits between a set of free-running clock sources and the output pads of a clock generator. It stops the outputs for power management and lets each output be switched off on its own. An active-low power-down pin, asynchronous to every clock, is resampled in the CPU clock domain. It counts as valid only when it reads low on two consecutive CPU rising edges. The block then raises a stop request for the oscillator and PLL, and parks each output low at that output's own next falling edge, so no shortened pulse ever reaches a pad.

When the pin is released, the stop request drops. After a programmable number of CPU reference cycles for settling, each output restarts cleanly on a rising edge of its source. A per-output enable vector holds individual outputs low while keeping them driven. A single tristate control drops the output-enable indication of every output at once.

Top module: `clkgate_pd`

## Requirements
- R1: While `rst_n` is low, `stop_req` is 0 and `clk_oe` is all ones. After reset, every enabled output follows its source, starting at that source's first falling edge.
- R2: `pd_n` passes through a two-stage synchroniser and must then read low on two consecutive CPU rising edges. If `pd_n` falls between two edges and stays low, `stop_req` is 0 after the third following `cpu_clk` rising edge and 1 after the fourth.
- R3: A low pulse on `pd_n` that spans exactly one `cpu_clk` rising edge never raises `stop_req`.
- R4: Once `stop_req` is 1, each `clk_out[i]` shows at most one more high pulse, ends it at a falling edge of `src_clk[i]`, and then stays low with `clk_oe[i]` still 1 for as long as power-down lasts.
- R5: Every high pulse on `clk_out[i]` lasts exactly the high phase of `src_clk[i]`, in every mode and at every transition. No runt pulses occur.
- R6: If `pd_n` rises between two edges while power-down is active, `stop_req` is 1 after the second following `cpu_clk` rising edge and 0 after the third.
- R7: After `stop_req` falls, no output rises until `SETTLE_CYCLES` more `cpu_clk` rising edges have passed. After that, each output rises again within three periods of its source.
- R8: Bit i of `out_en` (1 = run, 0 = held low) controls `clk_out[i]`. A 0 holds the output low from the next falling edge of its source, with `clk_oe[i]` kept at 1. A 1 resumes the output. This holds for every pattern of the vector.
- R9: `tristate_all` = 1 drives `clk_oe` to all zeros from the next `cpu_clk` rising edge, and 0 drives it back to all ones. The clock outputs themselves keep running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | CPU reference clock; samples power-down and times the settle wait |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| src_clk | input | N_OUT | Free-running source clocks, one per output |
| out_en | input | N_OUT | Per-output run enable, 1 = run |
| tristate_all | input | 1 | 1 = release all pads (output enables low) |
| clk_out | output | N_OUT | Gated clock outputs |
| clk_oe | output | N_OUT | Pad drive enable for each output |
| stop_req | output | 1 | Request to halt the oscillator and PLL |

## Verification
`stop_req` responds on the fourth CPU edge after `pd_n` falls and on the third after it rises. Run permission follows `SETTLE_CYCLES` edges after the release. `clk_oe` follows `tristate_all` one edge later. The bench drives inputs and samples 0.3 ns after a CPU rising edge, and it counts the exact edge at which each value is due. For a gated output, the change lands on the next falling edge of that output's own source. The bench therefore samples outputs 0.2 ns after source edges and measures every high pulse against the source's half period. It counts rising edges over windows several source periods long, so no result depends on which source edge arrives first.

// File: rtl/clkgate_pd_pkg.sv
`timescale 1ns/1ps
package clkgate_pd_pkg;
  // width of a counter that must reach max_val
  function automatic int cnt_bits(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

  // cpu edges from a pd_n fall to stop_req high
  function automatic int stop_latency(input int sync_stages, input int qual_samples);
    return sync_stages + qual_samples;
  endfunction

  // cpu edges from a pd_n rise to stop_req low
  function automatic int release_latency(input int sync_stages);
    return sync_stages + 1;
  endfunction
endpackage

// File: rtl/clkgate_pd_qual.sv
`timescale 1ns/1ps
module clkgate_pd_qual
  import clkgate_pd_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int QUAL_SAMPLES  = 2,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic cpu_clk,
  input  logic rst_n,
  input  logic pd_n,
  output logic pd_sync,
  output logic stop_req,
  output logic run_req
);
  localparam int CW = cnt_bits(SETTLE_CYCLES);
  localparam logic [CW-1:0] SETTLE_V = CW'(SETTLE_CYCLES);

  logic [SYNC_STAGES-1:0]  smp_q;
  logic [QUAL_SAMPLES-2:0] hist_q;
  logic [QUAL_SAMPLES-1:0] window;
  logic                    stop_q, stop_nxt;
  logic [CW-1:0]           settle_q;

  assign pd_sync = smp_q[SYNC_STAGES-1];
  assign window  = {hist_q, pd_sync};

  // set when every sample in the window reads low, clear as soon as the
  // synchronised pin reads high again
  assign stop_nxt = ~pd_sync & (stop_q | (window == '0));

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q    <= '1;
      hist_q   <= '1;
      stop_q   <= 1'b0;
      settle_q <= SETTLE_V;
    end else begin
      smp_q  <= {smp_q[SYNC_STAGES-2:0], pd_n};
      hist_q <= window[QUAL_SAMPLES-2:0];
      stop_q <= stop_nxt;
      if (stop_q)
        settle_q <= '0;
      else if (settle_q != SETTLE_V)
        settle_q <= settle_q + 1'b1;
    end
  end

  assign stop_req = stop_q;
  assign run_req  = ~stop_q & (settle_q == SETTLE_V);
endmodule

// File: rtl/clkgate_pd_cell.sv
`timescale 1ns/1ps
module clkgate_pd_cell (
  input  logic src_clk,
  input  logic rst_n,
  input  logic want_on,
  output logic clk_out
);
  logic gate_q;

  // enable captured only in the low phase of the source
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= want_on;
  end

  assign clk_out = src_clk & gate_q;
endmodule

// File: rtl/clkgate_pd_oe.sv
`timescale 1ns/1ps
module clkgate_pd_oe #(
  parameter int N_OUT = 3
) (
  input  logic             cpu_clk,
  input  logic             rst_n,
  input  logic             tristate_all,
  output logic [N_OUT-1:0] clk_oe
);
  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) clk_oe <= '1;
    else        clk_oe <= {N_OUT{~tristate_all}};
  end
endmodule

// File: rtl/clkgate_pd.sv
`timescale 1ns/1ps
module clkgate_pd #(
  parameter int N_OUT         = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int QUAL_SAMPLES  = 2,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic             cpu_clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic [N_OUT-1:0] src_clk,
  input  logic [N_OUT-1:0] out_en,
  input  logic             tristate_all,
  output logic [N_OUT-1:0] clk_out,
  output logic [N_OUT-1:0] clk_oe,
  output logic             stop_req
);
  // named internal events for the checker
  logic pd_sync_w;
  logic run_req_w;

  clkgate_pd_qual #(
    .SYNC_STAGES  (SYNC_STAGES),
    .QUAL_SAMPLES (QUAL_SAMPLES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_qual (
    .cpu_clk (cpu_clk),
    .rst_n   (rst_n),
    .pd_n    (pd_n),
    .pd_sync (pd_sync_w),
    .stop_req(stop_req),
    .run_req (run_req_w)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    clkgate_pd_cell u_cell (
      .src_clk(src_clk[i]),
      .rst_n  (rst_n),
      .want_on(run_req_w & out_en[i]),
      .clk_out(clk_out[i])
    );
  end

  clkgate_pd_oe #(.N_OUT(N_OUT)) u_oe (
    .cpu_clk     (cpu_clk),
    .rst_n       (rst_n),
    .tristate_all(tristate_all),
    .clk_oe      (clk_oe)
  );
endmodule

// File: rtl/clkgate_pd_chk.sv
`timescale 1ns/1ps
module clkgate_pd_chk #(
  parameter int N_OUT         = 3,
  parameter int SETTLE_CYCLES = 64
) (
  input logic             cpu_clk,
  input logic             rst_n,
  input logic             pd_sync,
  input logic             stop_req,
  input logic             run_req,
  input logic             tristate_all,
  input logic [N_OUT-1:0] clk_oe
);
  // cycles since stop_req was last high, saturating
  int unsigned quiet_cnt;
  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n)                     quiet_cnt <= SETTLE_CYCLES;
    else if (stop_req)              quiet_cnt <= 0;
    else if (quiet_cnt < SETTLE_CYCLES) quiet_cnt <= quiet_cnt + 1;
  end

  AST_STOP_TWO_LOW: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    $rose(stop_req) |-> (!$past(pd_sync) && !$past(pd_sync, 2))); // R2
  AST_RELEASE_ON_HIGH: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    $fell(stop_req) |-> $past(pd_sync)); // R6
  AST_NO_RUN_WHILE_STOP: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    stop_req |-> !run_req); // R4
  AST_SETTLE_WAIT: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    $rose(run_req) |-> (quiet_cnt >= SETTLE_CYCLES)); // R7
  AST_TRI_OFF: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    tristate_all |=> (clk_oe == '0)); // R9
  AST_TRI_ON: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    !tristate_all |=> (&clk_oe)); // R9
endmodule

bind clkgate_pd clkgate_pd_chk #(
  .N_OUT(N_OUT), .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
  .cpu_clk     (cpu_clk),
  .rst_n       (rst_n),
  .pd_sync     (pd_sync_w),
  .stop_req    (stop_req),
  .run_req     (run_req_w),
  .tristate_all(tristate_all),
  .clk_oe      (clk_oe)
);

// File: tb/clkgate_pd_bench.sv
`timescale 1ns/1ps
module clkgate_pd_bench;
  localparam int N      = 3;
  localparam int SETTLE = 6;

  logic         cpu_clk = 1'b0;
  logic         rst_n   = 1'b0;
  logic         pd_n    = 1'b1;
  logic [N-1:0] src_clk = '0;
  logic [N-1:0] out_en  = '1;
  logic         tri_all = 1'b0;
  logic [N-1:0] clk_out, clk_oe;
  logic         stop_req;

  int n_chk = 0, n_bad = 0;
  bit done = 0, wd_hit = 0;

  clkgate_pd #(.N_OUT(N), .SETTLE_CYCLES(SETTLE)) u_clkgate_pd (
    .cpu_clk(cpu_clk), .rst_n(rst_n), .pd_n(pd_n), .src_clk(src_clk),
    .out_en(out_en), .tristate_all(tri_all), .clk_out(clk_out),
    .clk_oe(clk_oe), .stop_req(stop_req)
  );

  // 250 MHz cpu clock; sources with edges never on a cpu edge
  initial forever #2 cpu_clk = ~cpu_clk;
  initial begin #1.0; forever #2 src_clk[0] = ~src_clk[0]; end
  initial begin #0.5; forever #3 src_clk[1] = ~src_clk[1]; end
  initial begin #1.5; forever #5 src_clk[2] = ~src_clk[2]; end

  function automatic real half_of(input int i);
    return (i == 0) ? 2.0 : (i == 1) ? 3.0 : 5.0;
  endfunction

  // per-output pulse-width monitor (R5) and rise counter
  for (genvar g = 0; g < N; g++) begin : g_mon
    real t_r  = -1.0;
    int  n_r  = 0;
    int  w_chk = 0, w_bad = 0;
    always @(posedge clk_out[g]) begin
      t_r = $realtime;
      n_r = n_r + 1;
    end
    always @(negedge clk_out[g]) begin
      if (rst_n && t_r >= 0.0) begin
        real w;
        w = $realtime - t_r;
        w_chk = w_chk + 1;
        if (w < half_of(g) - 0.01 || w > half_of(g) + 0.01) begin
          w_bad = w_bad + 1;
          $display("FAIL R5 out%0d pulse width act=%0.3f exp=%0.3f", g, w, half_of(g));
        end
      end
    end
  end

  function automatic int rises_of(input int i);
    case (i)
      0: return g_mon[0].n_r;
      1: return g_mon[1].n_r;
      default: return g_mon[2].n_r;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge cpu_clk);
    #0.3;
  endtask

  // output i mirrors its source in both phases
  task automatic probe(input int i, input string tag);
    wait (src_clk[i] == 1'b0); wait (src_clk[i] == 1'b1); #0.2;
    check(clk_out[i] == 1'b1, tag, int'(clk_out[i]), 1);
    wait (src_clk[i] == 1'b0); #0.2;
    check(clk_out[i] == 1'b0, tag, int'(clk_out[i]), 0);
  endtask

  task automatic finish_up;
    int tc, tb;
    tc = n_chk; tb = n_bad + (wd_hit ? 1 : 0);
    tc += g_mon[0].w_chk + g_mon[1].w_chk + g_mon[2].w_chk;
    tb += g_mon[0].w_bad + g_mon[1].w_bad + g_mon[2].w_bad;
    $display("  test done: total=%0d bad=%0d", tc, tb);
    $finish;
  endtask

  initial begin
    #(200000 * 4.0);
    if (!done) begin
      wd_hit = 1;
      $display("FAIL R1 watchdog act=running exp=finished");
      finish_up();
    end
  end

  initial begin
    int base[N];
    int mid[N];
    bit seen;
    #0.3;
    tick(1);
    check(stop_req == 1'b0, "R1 stop_req in reset", int'(stop_req), 0);
    check(clk_oe == 3'b111, "R1 clk_oe in reset", int'(clk_oe), 7);
    tick(4);
    rst_n = 1'b1;
    tick(6);
    check(stop_req == 1'b0, "R1 stop_req after reset", int'(stop_req), 0);
    for (int i = 0; i < N; i++) probe(i, "R1 output follows source");

    // R8 sweep over every enable pattern
    for (int p = 0; p < 8; p++) begin
      tick(1);
      out_en = 3'(p);
      tick(8);
      for (int i = 0; i < N; i++) base[i] = rises_of(i);
      tick(10);
      for (int i = 0; i < N; i++) begin
        int d;
        d = rises_of(i) - base[i];
        check((d > 0) == p[i], "R8 enable pattern rises", d, p[i] ? 1 : 0);
        if (!p[i]) check(clk_out[i] == 1'b0, "R8 disabled output low", int'(clk_out[i]), 0);
      end
      check(clk_oe == 3'b111, "R8 disabled output still driven", int'(clk_oe), 7);
    end
    out_en = '1;
    tick(8);

    // R9 tristate
    tri_all = 1'b1;
    tick(1);
    check(clk_oe == 3'b000, "R9 tristate oe low", int'(clk_oe), 0);
    probe(0, "R9 clock runs under tristate");
    tick(1);
    tri_all = 1'b0;
    tick(1);
    check(clk_oe == 3'b111, "R9 tristate released", int'(clk_oe), 7);

    // R3 one-edge glitch on pd_n
    tick(1);
    pd_n = 1'b0;
    tick(1);
    pd_n = 1'b1;
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      tick(1);
      if (stop_req) seen = 1;
    end
    check(!seen, "R3 glitch rejected", int'(seen), 0);
    probe(2, "R3 outputs still running");

    // R2 qualification latency
    tick(1);
    pd_n = 1'b0;
    tick(3);
    check(stop_req == 1'b0, "R2 stop_req after third edge", int'(stop_req), 0);
    tick(1);
    check(stop_req == 1'b1, "R2 stop_req after fourth edge", int'(stop_req), 1);
    for (int i = 0; i < N; i++) base[i] = rises_of(i);

    // R4 outputs park low
    tick(8);
    for (int i = 0; i < N; i++) begin
      mid[i] = rises_of(i);
      check(mid[i] - base[i] <= 1, "R4 at most one pulse after stop", mid[i] - base[i], 1);
    end
    tick(20);
    for (int i = 0; i < N; i++) begin
      check(rises_of(i) == mid[i], "R4 no pulses in power-down", rises_of(i) - mid[i], 0);
      check(clk_out[i] == 1'b0, "R4 output held low", int'(clk_out[i]), 0);
    end
    check(clk_oe == 3'b111, "R4 outputs driven in power-down", int'(clk_oe), 7);

    // R6 release latency
    pd_n = 1'b1;
    tick(2);
    check(stop_req == 1'b1, "R6 stop_req after second edge", int'(stop_req), 1);
    tick(1);
    check(stop_req == 1'b0, "R6 stop_req after third edge", int'(stop_req), 0);
    for (int i = 0; i < N; i++) base[i] = rises_of(i);

    // R7 settle wait then restart
    tick(SETTLE - 1);
    for (int i = 0; i < N; i++)
      check(rises_of(i) == base[i], "R7 no restart before settle", rises_of(i) - base[i], 0);
    tick(9);
    for (int i = 0; i < N; i++)
      check(rises_of(i) > base[i], "R7 restart after settle", rises_of(i) - base[i], 1);
    for (int i = 0; i < N; i++) probe(i, "R7 output follows source again");

    // R5 summary over all measured pulses
    check(g_mon[0].w_bad + g_mon[1].w_bad + g_mon[2].w_bad == 0, "R5 runt pulses",
          g_mon[0].w_bad + g_mon[1].w_bad + g_mon[2].w_bad, 0);

    done = 1;
    finish_up();
  end
endmodule